// File: doc/BRIEF.md
# Bicolor LED Pattern Controller

This block drives one front bicolor LED and five disk-bay bicolor LEDs. Each LED has a blue and a red channel. A host programs the block over a narrow write-only bus: a 3-bit address, a 3-bit data value and an enable strobe. The address and data are captured on the rising edge of the strobe, after the strobe has been synchronized to the system clock. Eight 3-bit registers sit behind the bus: the front mode, the front brightness, one brightness shared by all disk LEDs, and one mode for each disk LED.

Each mode code selects a steady colour or a blink pattern. The patterns are timed by a 0.5 s tick, which is divided down from the `CLK_HZ` parameter. A pattern phase counter repeats every 12 ticks (6 s). In activity mode, a disk LED is blue while the disk is idle. Each active-low activity pulse blanks the LED for a stretched minimum time of about 1/20 s. Brightness uses a 7-slot PWM whose duty is code/7, and the PWM gates both colours of an LED.

Top module: `bicolor_led_ctrl`

## Requirements
- R1: After reset all registers read as code 0, every LED output is low, and the pattern phase counter starts at phase 0.
- R2: A write takes place once per rising edge of the synchronized enable strobe, using the address and data present at that edge. While the strobe is held high, changes on the data lines do not write.
- R3: The address map is as follows. Address 0 is the front mode and address 1 is the front brightness. Address 2 is the shared disk brightness, and addresses 3 to 7 are the modes of disk LEDs 0 to 4.
- R4: The PWM slot counter runs 0..6. A channel that its mode enables is high in a slot exactly when the slot is below the brightness code, so the duty over every 7 clocks is code/7. Code 0 keeps the LED dark and code 7 keeps it fully on.
- R5: Front mode codes 0, 1 and 2 give steady off, steady blue and steady red. Blue and red are never high together on any LED.
- R6: Let t = 0.5 s × phase, and let the phase advance once per tick over 12 phases. Front mode 3 is blue when t mod 2 s < 1 s and off otherwise. Mode 4 is the same pattern in red. Mode 5 is blue when t mod 3 s < 2.5 s and red otherwise. Mode 6 is blue when t mod 2 s < 1 s and red otherwise. Mode 7 is blue when t mod 3 s < 0.5 s and off otherwise.
- R7: For disk mode codes, 0 is off, 2 is steady red and 7 is steady blue. Codes 3 to 6 follow the front patterns of R6.
- R8: In disk mode 1 the LED is blue while idle. An activity input that goes low for even one clock blanks that LED for at least `CLK_HZ/STRETCH_DIV` clocks, after which it returns to blue.
- R9: The shared disk brightness sets the duty of every disk LED. It is independent of the front brightness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_data_i | input | 3 | Register write value |
| bus_en_i | input | 1 | Write strobe, commits on its rising edge |
| disk_act_ni | input | 5 | Per-disk activity, active low |
| front_blue_o | output | 1 | Front LED blue channel |
| front_red_o | output | 1 | Front LED red channel |
| disk_blue_o | output | 5 | Disk LED blue channels |
| disk_red_o | output | 5 | Disk LED red channels |

## Verification
The bench builds the block with `CLK_HZ` = 640 and the default `STRETCH_DIV` of 20. One tick is then 320 clocks, a whole 12-phase pattern frame is 3840 clocks, and the activity stretch is 32 clocks. These values put every blink phase and the minimum-on window within a short run. Random mode writes are sampled in mid-phase, at many points of the frame, and checked against a time-based model. PWM duty is measured by counting high clocks over 700-clock windows, which are exact multiples of the 7-slot period.

// File: rtl/bled_pkg.sv
package bled_pkg;
  localparam int PHASES = 12;
  localparam int PWM_SLOTS = 7;

  typedef logic [2:0] code_t;
  typedef struct packed {
    logic blue;
    logic red;
  } color_t;

  // phase is in 0.5 s units over a 6 s frame
  function automatic color_t pattern(input code_t mode, input logic [3:0] ph,
                                     input logic disk, input logic busy);
    color_t c;
    logic [3:0] m6;
    logic       lo2;
    m6  = ph % 4'd6;
    lo2 = (ph[1:0] < 2'd2);
    c.blue = 1'b0;
    c.red  = 1'b0;
    case (mode)
      3'd1: c.blue = disk ? ~busy : 1'b1;
      3'd2: c.red  = 1'b1;
      3'd3: c.blue = lo2;
      3'd4: c.red  = lo2;
      3'd5: begin c.blue = (m6 < 4'd5); c.red = ~(m6 < 4'd5); end
      3'd6: begin c.blue = lo2; c.red = ~lo2; end
      3'd7: c.blue = disk ? 1'b1 : (m6 == 4'd0);
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/bled_bus_sync.sv
module bled_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wr_o
);
  logic [2:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= {en_q[1:0], en_i};
  end

  assign wr_o = en_q[1] & ~en_q[2];

  p_single_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
endmodule

// File: rtl/bled_regs.sv
module bled_regs import bled_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [2:0]      addr_i,
  input  code_t           data_i,
  output logic [7:0][2:0] regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   regs_o <= '0;
    else if (wr_i) regs_o[addr_i] <= data_i;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/bled_timebase.sv
module bled_timebase import bled_pkg::*; #(
  parameter int TICK_CYC = 25_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [3:0] phase_o,
  output logic [2:0] slot_o
);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);

  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == TICK_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt <= '0;
      phase_o  <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick) phase_o <= (phase_o == 4'(PHASES - 1)) ? 4'd0 : phase_o + 4'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_o <= '0;
    else         slot_o <= (slot_o == 3'(PWM_SLOTS - 1)) ? 3'd0 : slot_o + 3'd1;
  end

  p_phase_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && phase_o == 4'(PHASES - 1)) |=> phase_o == 4'd0);
  p_phase_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(phase_o));
endmodule

// File: rtl/bled_stretch.sv
module bled_stretch #(
  parameter int LANES    = 5,
  parameter int HOLD_CYC = 2_500_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] act_ni,
  output logic [LANES-1:0] busy_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD = HW'(HOLD_CYC);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0]    sync_q;
    logic [HW-1:0] cnt_q;
    logic          act_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= 2'b11;
      else         sync_q <= {sync_q[0], act_ni[i]};
    end
    assign act_s = ~sync_q[1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (act_s)         cnt_q <= HOLD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o[i] = act_s | (cnt_q != '0);

    p_stretch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_s |=> busy_o[i]);
  end
endmodule

// File: rtl/bicolor_led_ctrl.sv
module bicolor_led_ctrl import bled_pkg::*; #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int STRETCH_DIV = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] bus_addr_i,
  input  logic [2:0] bus_data_i,
  input  logic       bus_en_i,
  input  logic [4:0] disk_act_ni,
  output logic       front_blue_o,
  output logic       front_red_o,
  output logic [4:0] disk_blue_o,
  output logic [4:0] disk_red_o
);
  localparam int NDISK    = 5;
  localparam int TICK_CYC = CLK_HZ / 2;
  localparam int HOLD_CYC = CLK_HZ / STRETCH_DIV;
  localparam int A_FMODE  = 0;
  localparam int A_FBRT   = 1;
  localparam int A_DBRT   = 2;
  localparam int A_DMODE0 = 3;

  logic            wr;
  logic [7:0][2:0] regs;
  logic [3:0]      phase;
  logic [2:0]      slot;
  logic [NDISK-1:0] busy;

  bled_bus_sync u_sync (
    .clk_i, .rst_ni, .en_i(bus_en_i), .wr_o(wr)
  );

  bled_regs u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(bus_addr_i), .data_i(bus_data_i),
    .regs_o(regs)
  );

  bled_timebase #(.TICK_CYC(TICK_CYC)) u_tb (
    .clk_i, .rst_ni, .phase_o(phase), .slot_o(slot)
  );

  bled_stretch #(.LANES(NDISK), .HOLD_CYC(HOLD_CYC)) u_act (
    .clk_i, .rst_ni, .act_ni(disk_act_ni), .busy_o(busy)
  );

  color_t front_c;
  logic   front_on;
  logic   disk_on;

  assign front_c  = pattern(regs[A_FMODE], phase, 1'b0, 1'b0);
  assign front_on = (slot < regs[A_FBRT]);
  assign disk_on  = (slot < regs[A_DBRT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_blue_o <= 1'b0;
      front_red_o  <= 1'b0;
    end else begin
      front_blue_o <= front_c.blue & front_on;
      front_red_o  <= front_c.red  & front_on;
    end
  end

  for (genvar i = 0; i < NDISK; i++) begin : g_disk
    color_t c;
    assign c = pattern(regs[A_DMODE0 + i], phase, 1'b1, busy[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        disk_blue_o[i] <= 1'b0;
        disk_red_o[i]  <= 1'b0;
      end else begin
        disk_blue_o[i] <= c.blue & disk_on;
        disk_red_o[i]  <= c.red  & disk_on;
      end
    end

    p_disk_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(disk_blue_o[i] && disk_red_o[i]));
    p_disk_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (regs[A_DBRT] == 3'd0) |=> !(disk_blue_o[i] || disk_red_o[i]));
  end

  p_front_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(front_blue_o && front_red_o));
  p_front_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs[A_FBRT] == 3'd0) |=> !(front_blue_o || front_red_o));
  p_front_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs[A_FBRT] == 3'd7 && regs[A_FMODE] == 3'd1) |=> front_blue_o);
endmodule

// File: tb/sim_bicolor_led_ctrl.sv
module sim_bicolor_led_ctrl;
  localparam int CLK_HZ = 640;
  localparam int T      = CLK_HZ / 2;
  localparam int HOLD   = CLK_HZ / 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr = '0, data = '0;
  logic       en = 1'b0;
  logic [4:0] act_n = 5'h1f;
  logic       fb, fr;
  logic [4:0] db, dr;

  int checks = 0, bad = 0, cyc = 0;
  int shadow [8];

  always #2.5 clk = ~clk;

  bicolor_led_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_data_i(data),
    .bus_en_i(en), .disk_act_ni(act_n), .front_blue_o(fb), .front_red_o(fr),
    .disk_blue_o(db), .disk_red_o(dr)
  );

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d (cyc %0d)", req, got, exp, cyc);
    end
  endtask

  // {blue,red} from the time-based pattern definition
  function automatic int exp_led(int mode, int ph, bit disk, bit busy);
    int t = ph * 500;
    case (mode)
      1: return disk ? (busy ? 0 : 2) : 2;
      2: return 1;
      3: return (t % 2000 < 1000) ? 2 : 0;
      4: return (t % 2000 < 1000) ? 1 : 0;
      5: return (t % 3000 < 2500) ? 2 : 1;
      6: return (t % 2000 < 1000) ? 2 : 1;
      7: return disk ? 2 : ((t % 3000 < 500) ? 2 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); data = 3'(d); en = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    shadow[a] = d;
  endtask

  task automatic wait_mid();
    do @(negedge clk); while (cyc % T != T / 2);
  endtask

  // assumes brightness 7 everywhere and idle disks
  task automatic chk_all(input string req);
    int ph = (cyc / T) % 12;
    chk({req, " front"}, {fb, fr}, exp_led(shadow[0], ph, 0, 0));
    for (int i = 0; i < 5; i++)
      chk({req, " disk"}, {db[i], dr[i]}, exp_led(shadow[3 + i], ph, 1, 0));
  endtask

  task automatic count_front(output int n);
    n = 0;
    for (int k = 0; k < 700; k++) begin @(negedge clk); n += fb; end
  endtask

  task automatic count_disk(input int i, output int n);
    n = 0;
    for (int k = 0; k < 700; k++) begin @(negedge clk); n += db[i]; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {fb, fr, db, dr}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after reset", {fb, fr, db, dr}, 0);

    wr(1, 7);
    wr(2, 7);
    chk("R1 modes zero keep dark", {fb, fr, db, dr}, 0);
    wr(0, 1); wait_mid(); chk_all("R5 steady blue");
    wr(0, 2); wait_mid(); chk_all("R5 steady red");
    wr(0, 0); wait_mid(); chk_all("R5 off");

    // R2: data change while strobe held does not write
    @(negedge clk); addr = 3'd0; data = 3'd1; en = 1'b1;
    repeat (4) @(negedge clk); data = 3'd2;
    repeat (6) @(negedge clk); en = 1'b0;
    repeat (4) @(negedge clk); shadow[0] = 1;
    chk("R2 held strobe", {fb, fr}, 2);

    // R6/R7: directed sweep of front mode 5 and disk 4 mode 7 over a frame
    wr(0, 5); wr(7, 7);
    for (int p = 0; p < 12; p++) begin wait_mid(); chk_all("R6 R7 sweep"); end

    for (int it = 0; it < 40; it++) begin
      int a = ($urandom % 6 == 0) ? 0 : 3 + $urandom % 5;
      wr(a, $urandom % 8);
      for (int s = 0; s < 2; s++) begin
        repeat ($urandom % 3) wait_mid();
        wait_mid();
        chk_all(a == 0 ? "R6 random" : "R7 random");
      end
    end

    // R4: duty per brightness code
    wr(0, 1);
    foreach (shadow[i]) if (i >= 3) wr(i, 0);
    for (int b = 0; b <= 7; b += (b == 0 ? 3 : 2)) begin
      wr(1, b); count_front(n); chk("R4 duty", n, b * 100);
    end
    // R9: shared disk brightness, separate from front
    wr(1, 7); wr(3, 7); wr(5, 2); wr(2, 2);
    count_disk(0, n); chk("R9 disk0 duty", n, 200);
    count_disk(2, n); chk("R9 disk2 red duty", n, 0);
    count_front(n);   chk("R9 front unaffected", n, 700);

    // R8: activity stretch
    wr(2, 7); wr(4, 1);
    repeat (3) @(negedge clk);
    chk("R8 idle blue", {db[1], dr[1]}, 2);
    act_n[1] = 1'b0; @(negedge clk); act_n[1] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 blanked", {db[1], dr[1]}, 0);
    repeat (HOLD - 7) @(negedge clk);
    chk("R8 min on-time", {db[1], dr[1]}, 0);
    repeat (14) @(negedge clk);
    chk("R8 back to blue", {db[1], dr[1]}, 2);

    // R3: typical bring-up sequence
    for (int i = 0; i < 8; i++) wr(i, 0);
    wr(0, 1); wr(1, 3); wr(3, 1); wr(4, 1); wr(2, 3);
    count_front(n);   chk("R3 front bright 3", n, 300);
    count_disk(0, n); chk("R3 disk0 idle duty", n, 300);
    count_disk(1, n); chk("R3 disk1 idle duty", n, 300);
    n = 0;
    for (int k = 0; k < 70; k++) begin @(negedge clk); n += db[4:2] | dr[4:2] | fr; end
    chk("R3 others dark", n, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule